// File: doc/BRIEF.md
# Frequency-Locked Loop Integrator Core

This block is the digital part of a frequency-locked loop. It runs on the oscillator clock and holds an up/down integrator. The loop reaches balance when the integrator's two event rates match. Rising edges of a slow reference clock are synchronised and then divided by a selectable ratio. Each divided edge adds one to the integrator. The oscillator's own clock is counted down by a programmable feedback ratio, pre-divider times (multiplier + 1). Each expiry of that count subtracts one.

The integrator's upper five bits select one of 32 coarse oscillator taps. The lower bits form a fractional value for a modulator that mixes two adjacent taps. When the fractional output is masked, only the integer tap reaches the oscillator. Here is an example. A 32768 Hz reference, a pre-divider of 1 and a multiplier of 449 settle the loop near 450 × 32768 Hz = 14.7456 MHz.

Top module: `fll_core`

## Requirements
- R1: While the synchronous reset `rst` is high, each clock edge loads the integrator with `init_tap` in the upper five bits and zero in the lower five, so `tap_out` equals `init_tap` and `mod_out` is 0.
- R2: `ref_in` passes through a two-flop synchroniser and then a rising-edge detector. If `ref_in` rises before clock edge k, the integrator changes at edge k+2 and not before. A level that stays high counts only once.
- R3: `ref_div_sel` picks how many detected reference edges make one increment: 0→1, 1→2, 2→4, 3→8, 4→12, 5→16, and 6 or 7→16.
- R4: The integrator decrements once every D×(N+1) clock cycles. N is `fb_mult` (10 bits). D comes from `fb_pre_sel`: 0→1, 1→2, 2→4, 3→8, 4→16, 5→32, and 6 or 7→32. After reset is released, the first decrement lands on the D×(N+1)-th clock edge.
- R5: `tap_out` is integrator bits [9:5] and `mod_out` is bits [4:0].
- R6: While `dis_mod` is high, `mod_out` reads 0 and `tap_out` is unchanged. The integrator keeps counting, so the fraction it holds reappears when `dis_mod` drops.
- R7: An increment at the all-ones value (1023) leaves the integrator at 1023.
- R8: A decrement at zero leaves the integrator at zero.
- R9: An increment and a decrement that fall in the same cycle cancel, and the integrator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous reference clock |
| ref_div_sel | input | 3 | Reference divide-ratio select |
| fb_mult | input | 10 | Feedback multiplier N |
| fb_pre_sel | input | 3 | Feedback pre-divider select D |
| dis_mod | input | 1 | Mask the fractional output |
| init_tap | input | 5 | Tap loaded at reset |
| tap_out | output | 5 | Coarse oscillator tap |
| mod_out | output | 5 | Fractional modulation value |

## Verification
The bench targets saturation at both ends. A design that wraps there would jump from 1023 to 0, or from 0 to 1023, and the oscillator would be thrown across its whole range. It checks coincident up and down events with a divide-by-one feedback ratio. A design that lets either event win would drift by one count per reference edge. It measures the latency of a reference edge and the exact decrement count over a fixed window. An off-by-one in the synchroniser depth or in the feedback terminal count shows up as a wrong value in a known cycle. Random configurations, including the top divider encodings, are compared cycle by cycle against a bench model built from the requirements.

// File: rtl/fll_pkg.sv
package fll_pkg;

    localparam int SEL_W = 3;

    // one integrator step request
    typedef struct packed {
        logic up;
        logic dn;
    } step_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    function automatic step_e decode_step(input step_t s);
        if (s.up && !s.dn)      return STEP_INC;
        else if (s.dn && !s.up) return STEP_DEC;
        else                    return STEP_HOLD;
    endfunction

    // reference edges per increment
    function automatic logic [4:0] ref_ratio(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return 5'd1;
            3'd1:    return 5'd2;
            3'd2:    return 5'd4;
            3'd3:    return 5'd8;
            3'd4:    return 5'd12;
            default: return 5'd16;
        endcase
    endfunction

    // feedback pre-divider D, power of two capped at 32
    function automatic logic [5:0] pre_ratio(input logic [SEL_W-1:0] sel);
        if (sel > 3'd5) return 6'd32;
        return 6'd1 << sel;
    endfunction

endpackage

// File: rtl/fll_ref_sync.sv
module fll_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic ref_edge
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= 1'b0;
        else     pipe[0] <= ref_in;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[i] <= 1'b0;
            else     pipe[i] <= pipe[i-1];
        end
    end

    // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its delayed copy
    assign ref_edge = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/fll_ref_div.sv
module fll_ref_div
    import fll_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_edge,
    input  logic [SEL_W-1:0] div_sel,
    output logic             up_tick
);
    logic [4:0] cnt_q;
    logic [4:0] last;

    assign last    = ref_ratio(div_sel) - 5'd1;
    assign up_tick = ref_edge && (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst)           cnt_q <= '0;
        else if (up_tick)  cnt_q <= '0;
        else if (ref_edge) cnt_q <= cnt_q + 5'd1;
    end
endmodule

// File: rtl/fll_fb_div.sv
module fll_fb_div
    import fll_pkg::*;
#(
    parameter int N_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_W-1:0]   mult,
    input  logic [SEL_W-1:0] pre_sel,
    output logic             dn_tick
);
    localparam int LIM_W = N_W + 7;

    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] cnt_q;

    assign limit   = LIM_W'(pre_ratio(pre_sel)) * (LIM_W'(mult) + LIM_W'(1));
    // >= so a shortened ratio takes effect at once
    assign dn_tick = (cnt_q >= limit - LIM_W'(1));

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (dn_tick) cnt_q <= '0;
        else              cnt_q <= cnt_q + LIM_W'(1);
    end
endmodule

// File: rtl/fll_integrator.sv
module fll_integrator
    import fll_pkg::*;
#(
    parameter int TAP_W = 5,
    parameter int MOD_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [TAP_W-1:0]         init_tap,
    input  step_t                    step,
    output logic [TAP_W+MOD_W-1:0]   value
);
    localparam int W = TAP_W + MOD_W;
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= {init_tap, {MOD_W{1'b0}}};
        end else begin
            unique case (decode_step(step))
                STEP_INC: if (val_q != TOP) val_q <= val_q + W'(1);
                STEP_DEC: if (val_q != '0)  val_q <= val_q - W'(1);
                default:  val_q <= val_q;
            endcase
        end
    end

    assign value = val_q;
endmodule

// File: rtl/fll_core.sv
module fll_core
    import fll_pkg::*;
#(
    parameter int TAP_W = 5,
    parameter int MOD_W = 5,
    parameter int N_W   = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic [2:0]       ref_div_sel,
    input  logic [N_W-1:0]   fb_mult,
    input  logic [2:0]       fb_pre_sel,
    input  logic             dis_mod,
    input  logic [TAP_W-1:0] init_tap,
    output logic [TAP_W-1:0] tap_out,
    output logic [MOD_W-1:0] mod_out
);
    localparam int W = TAP_W + MOD_W;

    logic         ref_edge;
    logic         up_tick;
    logic         dn_tick;
    logic [W-1:0] integ;
    step_t        step;

    fll_ref_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .ref_in(ref_in), .ref_edge(ref_edge)
    );

    fll_ref_div u_rdiv (
        .clk(clk), .rst(rst), .ref_edge(ref_edge),
        .div_sel(ref_div_sel), .up_tick(up_tick)
    );

    fll_fb_div #(.N_W(N_W)) u_fdiv (
        .clk(clk), .rst(rst), .mult(fb_mult),
        .pre_sel(fb_pre_sel), .dn_tick(dn_tick)
    );

    assign step.up = up_tick;
    assign step.dn = dn_tick;

    fll_integrator #(.TAP_W(TAP_W), .MOD_W(MOD_W)) u_int (
        .clk(clk), .rst(rst), .init_tap(init_tap),
        .step(step), .value(integ)
    );

    assign tap_out = integ[W-1:MOD_W];
    assign mod_out = dis_mod ? '0 : integ[MOD_W-1:0];
endmodule

// File: rtl/fll_core_chk.sv
module fll_core_chk #(
    parameter int TAP_W = 5,
    parameter int MOD_W = 5
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   dis_mod,
    input logic [TAP_W-1:0]       init_tap,
    input logic                   up_tick,
    input logic                   dn_tick,
    input logic [TAP_W+MOD_W-1:0] integ,
    input logic [MOD_W-1:0]       mod_out
);
    localparam int W = TAP_W + MOD_W;
    localparam logic [W-1:0] TOP = '1;

    assert_reset_load_R1: assert property (@(posedge clk)
        rst |=> integ == {$past(init_tap), {MOD_W{1'b0}}});

    assert_mask_mod_R6: assert property (@(posedge clk) disable iff (rst)
        dis_mod |-> mod_out == '0);

    assert_sat_top_R7: assert property (@(posedge clk) disable iff (rst)
        (integ == TOP && up_tick && !dn_tick) |=> integ == TOP);

    assert_sat_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (integ == '0 && dn_tick && !up_tick) |=> integ == '0);

    assert_cancel_R9: assert property (@(posedge clk) disable iff (rst)
        (up_tick && dn_tick) |=> $stable(integ));

    assert_step_up_R3: assert property (@(posedge clk) disable iff (rst)
        (up_tick && !dn_tick && integ != TOP) |=> integ == $past(integ) + W'(1));

    assert_step_dn_R4: assert property (@(posedge clk) disable iff (rst)
        (dn_tick && !up_tick && integ != '0) |=> integ == $past(integ) - W'(1));
endmodule

bind fll_core fll_core_chk #(.TAP_W(TAP_W), .MOD_W(MOD_W)) u_chk (
    .clk(clk), .rst(rst), .dis_mod(dis_mod), .init_tap(init_tap),
    .up_tick(up_tick), .dn_tick(dn_tick), .integ(integ), .mod_out(mod_out)
);

// File: tb/tb_fll_core.sv
`timescale 1ns/1ps
module tb_fll_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_in = 1'b0;
    logic [2:0] ref_div_sel = 3'd0;
    logic [9:0] fb_mult = 10'd1023;
    logic [2:0] fb_pre_sel = 3'd5;
    logic       dis_mod = 1'b0;
    logic [4:0] init_tap = 5'd12;
    logic [4:0] tap_out;
    logic [4:0] mod_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fll_core dut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .ref_div_sel(ref_div_sel),
        .fb_mult(fb_mult), .fb_pre_sel(fb_pre_sel), .dis_mod(dis_mod),
        .init_tap(init_tap), .tap_out(tap_out), .mod_out(mod_out)
    );

    function automatic int rdiv(input logic [2:0] s);
        case (s)
            0: return 1;  1: return 2;  2: return 4;
            3: return 8;  4: return 12; default: return 16;
        endcase
    endfunction

    function automatic int pdiv(input logic [2:0] s);
        case (s)
            0: return 1;  1: return 2;  2: return 4;
            3: return 8;  4: return 16; default: return 32;
        endcase
    endfunction

    // behavioural model of the requirements
    int m_val, m_rc, m_fc;
    bit m_s1, m_s2, m_s3;
    always @(posedge clk) begin
        if (rst) begin
            m_val = int'(init_tap) * 32;
            m_rc = 0; m_fc = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            automatic bit e  = m_s2 && !m_s3;
            automatic bit up = e && (m_rc >= rdiv(ref_div_sel) - 1);
            automatic bit dn = (m_fc >= pdiv(fb_pre_sel) * (int'(fb_mult) + 1) - 1);
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ref_in;
            if (up) m_rc = 0; else if (e) m_rc = m_rc + 1;
            m_fc = dn ? 0 : m_fc + 1;
            if (up && !dn && m_val != 1023) m_val = m_val + 1;
            else if (dn && !up && m_val != 0) m_val = m_val - 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int outval();
        return int'(tap_out) * 32 + int'(mod_out);
    endfunction

    task automatic do_reset(input logic [4:0] t);
        @(negedge clk);
        rst = 1'b1; init_tap = t; ref_in = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            ref_in = 1'b1; repeat (3) @(negedge clk);
            ref_in = 1'b0; repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R1 reset state
        do_reset(5'd12);
        chk("R1 tap", tap_out, 12);
        chk("R1 mod", mod_out, 0);

        // R2 latency: rise before edge k, change at edge k+2
        ref_div_sel = 3'd0;
        ref_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 no change yet", outval(), 384);
        @(negedge clk);
        chk("R2 one increment", outval(), 385);
        repeat (6) @(negedge clk);
        chk("R2 held level counts once", outval(), 385);
        ref_in = 1'b0; repeat (3) @(negedge clk);

        // R3 divide by 4: eight edges give two increments
        do_reset(5'd12);
        ref_div_sel = 3'd2;
        pulse(8);
        chk("R3 div4", outval(), 386);
        // R5 field split
        chk("R5 tap", tap_out, 12);
        chk("R5 mod", mod_out, 2);

        // R6 masking
        dis_mod = 1'b1; @(negedge clk);
        chk("R6 masked mod", mod_out, 0);
        chk("R6 tap kept", tap_out, 12);
        ref_div_sel = 3'd0; pulse(1);
        dis_mod = 1'b0; @(negedge clk);
        chk("R6 fraction retained", mod_out, 3);

        // R3 top encodings divide by 16
        do_reset(5'd12);
        ref_div_sel = 3'd7; pulse(32);
        chk("R3 sel7 div16", outval(), 386);

        // R4 decrement window: N=9, D=1 -> ten in 100 cycles
        fb_mult = 10'd9; fb_pre_sel = 3'd0;
        do_reset(5'd12);
        repeat (100) @(negedge clk);
        chk("R4 D1 N9", outval(), 374);
        fb_pre_sel = 3'd1;
        do_reset(5'd12);
        repeat (100) @(negedge clk);
        chk("R4 D2 N9", outval(), 379);

        // R7 saturation at the top
        fb_mult = 10'd1023; fb_pre_sel = 3'd5; ref_div_sel = 3'd0;
        do_reset(5'd31);
        pulse(40);
        chk("R7 top", outval(), 1023);

        // R8 saturation at zero
        fb_mult = 10'd0; fb_pre_sel = 3'd0;
        do_reset(5'd0);
        repeat (20) @(negedge clk);
        chk("R8 zero", outval(), 0);

        // R9 cancel: down every cycle, four ups coincide
        do_reset(5'd5);
        pulse(4);
        chk("R9 cancel", outval(), 140);

        // random segments against the model (R3/R4/R9)
        for (int seg = 0; seg < 24; seg++) begin
            @(negedge clk);
            ref_div_sel = 3'($urandom_range(0, 7));
            fb_pre_sel  = 3'($urandom_range(0, 7));
            fb_mult     = 10'($urandom_range(0, 12));
            dis_mod     = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 2) == 0) do_reset(5'($urandom_range(0, 31)));
            for (int c = 0; c < 500; c++) begin
                @(negedge clk);
                chk("R3/R4/R9 model tap", tap_out, m_val / 32);
                chk("R3/R4/R9 model mod", mod_out, dis_mod ? 0 : m_val % 32);
                if ($urandom_range(0, 3) == 0) ref_in = ~ref_in;
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule